// File: doc/BRIEF.md
# Configurable GPIO Port Bank

The block holds a bank of 8-bit bidirectional I/O ports behind a simple synchronous register bus. Every port owns a configuration register, an output data register and a read-only location that returns the synchronized pin levels. One configuration bit and one data bit together decide, per pin, whether the pad floats, floats with a weak pull-up, or is driven low or high. The block feeds the pad cells through three vectors: output enable, output value and pull-up enable.

One port, chosen by a parameter, is special. Its pins 6 and 7 have fixed roles, so their register bits are reused. Data bits 7 and 6 request the two low-power modes. They are not stored and always read back as zero. Configuration bits 6 and 7 select the serial clock phase and the start-up delay on wake. Two static option inputs can take over pin 1 (watchdog output) and pin 7 (oscillator clock output). When pin 7 is an input, a rising level on it raises a wake pulse.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous active-high reset, every configuration and data register reads 0 and all pads not taken over by an option input are undriven with no pull-up. The haltReq, idleReq, altSkPhase and clkStartDelay outputs are 0.
- R2: For an ordinary pin with configuration bit c and data bit d: (c,d)=00 gives a floating input (oe=0, pull=0), 01 a pull-up input (oe=0, pull=1), 10 drives low (oe=1, out=0) and 11 drives high (oe=1, out=1). The out value is 0 whenever oe is 0.
- R3: regSel chooses what a read or write touches. 0 is the configuration register and 1 is the data register, and both read back what was written. 2 returns the pin levels two clock edges after they are applied. 3 reads 0. Writes with regSel 2 or 3 change nothing.
- R4: A write with regSel 1 to the special port with wrData bit 7 set makes haltReq high for exactly the one cycle after the write edge.
- R5: The same write with wrData bit 6 set makes idleReq high for exactly the one cycle after the write edge.
- R6: Data bits 7 and 6 of the special port always read 0. Its other data bits read back as written.
- R7: Configuration bit 6 of the special port drives altSkPhase. Configuration bit 7 of the special port drives clkStartDelay.
- R8: Pin 6 of the special port is always a floating input (oe=0, pull=0), whatever its register bits hold.
- R9: While wdogEnable is 1, pin 1 of the special port has pull=1 and out=0, and oe is the inverse of wdogSig. Its register bits have no effect on it.
- R10: While crystalMode is 1, pin 7 of the special port drives oscOut (oe=1). Otherwise it floats, and a 0-to-1 change of its synchronized level makes wakeReq high for one cycle, two cycles after the pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Single-cycle write strobe |
| portSel | input | $clog2(NUM_PORTS) | Port index |
| regSel | input | 2 | Register selector (0 config, 1 data, 2 pins, 3 none) |
| wrData | input | PORT_W | Write data |
| rdData | output | PORT_W | Combinational read data |
| padIn | input | NUM_PORTS*PORT_W | Pin levels from the pads |
| padOe | output | NUM_PORTS*PORT_W | Pad output enables |
| padOut | output | NUM_PORTS*PORT_W | Pad output values |
| padPullUp | output | NUM_PORTS*PORT_W | Pad weak pull-up enables |
| wdogEnable | input | 1 | Static watchdog pin option |
| wdogSig | input | 1 | Watchdog output level |
| crystalMode | input | 1 | Static crystal clock option |
| oscOut | input | 1 | Oscillator clock to place on pin 7 |
| haltReq | output | 1 | HALT request pulse |
| idleReq | output | 1 | IDLE request pulse |
| wakeReq | output | 1 | HALT-exit wake pulse from pin 7 |
| altSkPhase | output | 1 | Alternate serial clock phase select |
| clkStartDelay | output | 1 | Clock start-up delay enable |

## Verification
The pin mode encoding is tried with random configuration and data bytes written to random ports. Each write is compared with a bench model of all four modes, so a swapped bit or a missed port index shows up on the pad vectors. Random data writes to the special port tell the stored bits apart from the request bits. The two request pulses are checked against whichever of bits 7 and 6 the write carried. Directed patterns switch the two option inputs with register contents that would otherwise drive the pins. They also raise pin 7 with and without crystal mode, which separates the fixed pin roles and the wake edge from the ordinary pin path.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_DAT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    cfgWr;
    logic    datWr;
    logic    rdValid;
    regSel_e rdKind;
  } strobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int SPECIAL_PORT = 1,
  parameter int PIDX_W       = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [PIDX_W-1:0] portSel,
  input  logic [1:0]        regSel,
  input  logic [1:0]        reqBits,
  output strobe_t           strb,
  output logic              haltReq,
  output logic              idleReq
);
  logic    portOk;
  logic    isSpecial;
  regSel_e kind;

  assign kind      = regSel_e'(regSel);
  assign portOk    = (int'(portSel) < NUM_PORTS);
  assign isSpecial = portOk && (int'(portSel) == SPECIAL_PORT);

  always_comb begin
    strb.cfgWr   = wrEn && portOk && (kind == SEL_CFG);
    strb.datWr   = wrEn && portOk && (kind == SEL_DAT);
    strb.rdValid = portOk;
    strb.rdKind  = kind;
  end

  // request pulses are registered one cycle after the write edge
  always_ff @(posedge clk) begin
    if (rst) begin
      haltReq <= 1'b0;
      idleReq <= 1'b0;
    end else begin
      haltReq <= strb.datWr && isSpecial && reqBits[1];
      idleReq <= strb.datWr && isSpecial && reqBits[0];
    end
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int PORT_W       = 8,
  parameter int SPECIAL_PORT = 1,
  parameter int PIDX_W       = $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  strobe_t                     strb,
  input  logic [PIDX_W-1:0]           portSel,
  input  logic [PORT_W-1:0]           wrData,
  output logic [PORT_W-1:0]           rdData,
  input  logic [NUM_PORTS*PORT_W-1:0] padIn,
  output logic [NUM_PORTS*PORT_W-1:0] padOe,
  output logic [NUM_PORTS*PORT_W-1:0] padOut,
  output logic [NUM_PORTS*PORT_W-1:0] padPullUp,
  input  logic                        wdogEnable,
  input  logic                        wdogSig,
  input  logic                        crystalMode,
  input  logic                        oscOut,
  output logic                        wakeReq,
  output logic                        altSkPhase,
  output logic                        clkStartDelay
);
  localparam int TOTAL_W  = NUM_PORTS * PORT_W;
  localparam int PIN7_IDX = SPECIAL_PORT * PORT_W + 7;
  localparam logic [PORT_W-1:0] SPECIAL_MASK = ~(PORT_W'(3) << 6);

  logic [PORT_W-1:0]  cfgQ [NUM_PORTS];
  logic [PORT_W-1:0]  datQ [NUM_PORTS];
  logic [PORT_W-1:0]  pinView [NUM_PORTS];
  logic [TOTAL_W-1:0] syncA, syncB;
  logic               pin7Prev;

  // configuration and data storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        cfgQ[p] <= '0;
        datQ[p] <= '0;
      end
    end else begin
      if (strb.cfgWr) cfgQ[portSel] <= wrData;
      if (strb.datWr)
        datQ[portSel] <= (int'(portSel) == SPECIAL_PORT) ? (wrData & SPECIAL_MASK) : wrData;
    end
  end

  // two-flop input synchronizer plus edge history for pin 7
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA    <= '0;
      syncB    <= '0;
      pin7Prev <= 1'b0;
    end else begin
      syncA    <= padIn;
      syncB    <= syncA;
      pin7Prev <= syncB[PIN7_IDX];
    end
  end

  assign wakeReq       = !crystalMode && syncB[PIN7_IDX] && !pin7Prev;
  assign altSkPhase    = cfgQ[SPECIAL_PORT][6];
  assign clkStartDelay = cfgQ[SPECIAL_PORT][7];

  // pad control per pin, with fixed roles on the special port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign pinView[p] = syncB[p*PORT_W +: PORT_W];
    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
      localparam int IDX = p * PORT_W + b;
      if (p == SPECIAL_PORT && b == 6) begin : g_inOnly
        assign padOe[IDX]     = 1'b0;
        assign padOut[IDX]    = 1'b0;
        assign padPullUp[IDX] = 1'b0;
      end else if (p == SPECIAL_PORT && b == 7) begin : g_clkPin
        assign padOe[IDX]     = crystalMode;
        assign padOut[IDX]    = crystalMode & oscOut;
        assign padPullUp[IDX] = 1'b0;
      end else if (p == SPECIAL_PORT && b == 1) begin : g_wdogPin
        assign padOe[IDX]     = wdogEnable ? !wdogSig : cfgQ[p][b];
        assign padOut[IDX]    = wdogEnable ? 1'b0 : (cfgQ[p][b] & datQ[p][b]);
        assign padPullUp[IDX] = wdogEnable ? 1'b1 : (!cfgQ[p][b] & datQ[p][b]);
      end else begin : g_plain
        assign padOe[IDX]     = cfgQ[p][b];
        assign padOut[IDX]    = cfgQ[p][b] & datQ[p][b];
        assign padPullUp[IDX] = !cfgQ[p][b] & datQ[p][b];
      end
    end
  end

  // combinational read mux
  always_comb begin
    rdData = '0;
    if (strb.rdValid) begin
      case (strb.rdKind)
        SEL_CFG: rdData = cfgQ[portSel];
        SEL_DAT: rdData = datQ[portSel];
        SEL_PIN: rdData = pinView[portSel];
        default: rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int PORT_W       = 8,
  parameter int SPECIAL_PORT = 1,
  parameter int PIDX_W       = $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wrEn,
  input  logic [PIDX_W-1:0]           portSel,
  input  logic [1:0]                  regSel,
  input  logic [PORT_W-1:0]           wrData,
  output logic [PORT_W-1:0]           rdData,
  input  logic [NUM_PORTS*PORT_W-1:0] padIn,
  output logic [NUM_PORTS*PORT_W-1:0] padOe,
  output logic [NUM_PORTS*PORT_W-1:0] padOut,
  output logic [NUM_PORTS*PORT_W-1:0] padPullUp,
  input  logic                        wdogEnable,
  input  logic                        wdogSig,
  input  logic                        crystalMode,
  input  logic                        oscOut,
  output logic                        haltReq,
  output logic                        idleReq,
  output logic                        wakeReq,
  output logic                        altSkPhase,
  output logic                        clkStartDelay
);
  strobe_t strb;

  gpio_bank_ctrl #(
    .NUM_PORTS(NUM_PORTS), .SPECIAL_PORT(SPECIAL_PORT), .PIDX_W(PIDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .portSel(portSel), .regSel(regSel),
    .reqBits(wrData[7:6]), .strb(strb), .haltReq(haltReq), .idleReq(idleReq)
  );

  gpio_bank_dp #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .SPECIAL_PORT(SPECIAL_PORT), .PIDX_W(PIDX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .portSel(portSel), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOe(padOe), .padOut(padOut),
    .padPullUp(padPullUp), .wdogEnable(wdogEnable), .wdogSig(wdogSig),
    .crystalMode(crystalMode), .oscOut(oscOut), .wakeReq(wakeReq),
    .altSkPhase(altSkPhase), .clkStartDelay(clkStartDelay)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PORTS    = 4,
  parameter int SPECIAL_PORT = 1,
  parameter int PIDX_W       = $clog2(NUM_PORTS)
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [PIDX_W-1:0] portSel,
  input logic [1:0]        regSel,
  input logic [1:0]        reqBits,
  input logic [1:0]        rdHi,
  input logic              p1Oe,
  input logic              p1Out,
  input logic              p1Pull,
  input logic              p6Oe,
  input logic              p6Pull,
  input logic              p7Oe,
  input logic              p7Out,
  input logic              haltReq,
  input logic              idleReq,
  input logic              wakeReq,
  input logic              altSkPhase,
  input logic              clkStartDelay,
  input logic              wdogEnable,
  input logic              wdogSig,
  input logic              crystalMode,
  input logic              oscOut
);
  logic specialDataWr;
  assign specialDataWr = wrEn && (regSel == 2'd1) && (int'(portSel) == SPECIAL_PORT);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!haltReq && !idleReq && !altSkPhase && !clkStartDelay));

  // R4
  halt_src_chk: assert property (@(posedge clk) disable iff (rst)
    haltReq |-> $past(specialDataWr && reqBits[1]));

  // R5
  idle_src_chk: assert property (@(posedge clk) disable iff (rst)
    idleReq |-> $past(specialDataWr && reqBits[0]));

  // R6
  special_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (regSel == 2'd1 && int'(portSel) == SPECIAL_PORT) |-> (rdHi == 2'b00));

  // R8
  pin6_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !p6Oe && !p6Pull);

  // R9
  wdog_pin_chk: assert property (@(posedge clk) disable iff (rst)
    wdogEnable |-> (p1Pull && !p1Out && (p1Oe == !wdogSig)));

  // R10
  xtal_pin_chk: assert property (@(posedge clk) disable iff (rst)
    crystalMode |-> (p7Oe && (p7Out == oscOut)));

  // R10
  wake_width_chk: assert property (@(posedge clk) disable iff (rst)
    wakeReq |=> !wakeReq);
endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .SPECIAL_PORT(SPECIAL_PORT), .PIDX_W(PIDX_W)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .portSel(portSel), .regSel(regSel),
  .reqBits(wrData[7:6]), .rdHi(rdData[7:6]),
  .p1Oe(padOe[SPECIAL_PORT*PORT_W+1]), .p1Out(padOut[SPECIAL_PORT*PORT_W+1]),
  .p1Pull(padPullUp[SPECIAL_PORT*PORT_W+1]),
  .p6Oe(padOe[SPECIAL_PORT*PORT_W+6]), .p6Pull(padPullUp[SPECIAL_PORT*PORT_W+6]),
  .p7Oe(padOe[SPECIAL_PORT*PORT_W+7]), .p7Out(padOut[SPECIAL_PORT*PORT_W+7]),
  .haltReq(haltReq), .idleReq(idleReq), .wakeReq(wakeReq),
  .altSkPhase(altSkPhase), .clkStartDelay(clkStartDelay),
  .wdogEnable(wdogEnable), .wdogSig(wdogSig), .crystalMode(crystalMode), .oscOut(oscOut)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int NP = 4;
  localparam int W  = 8;
  localparam int SP = 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, wrEn, wdogEnable, wdogSig, crystalMode, oscOut;
  logic [1:0] portSel, regSel;
  logic [W-1:0] wrData, rdData;
  logic [NP*W-1:0] padIn, padOe, padOut, padPullUp;
  logic haltReq, idleReq, wakeReq, altSkPhase, clkStartDelay;

  gpio_bank uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .portSel(portSel), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .padPullUp(padPullUp), .wdogEnable(wdogEnable),
    .wdogSig(wdogSig), .crystalMode(crystalMode), .oscOut(oscOut),
    .haltReq(haltReq), .idleReq(idleReq), .wakeReq(wakeReq),
    .altSkPhase(altSkPhase), .clkStartDelay(clkStartDelay)
  );

  int nChecks = 0;
  int nFail = 0;
  logic [W-1:0] cfgM [NP];
  logic [W-1:0] datM [NP];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {oe, out, pull} expected for one pin
  function automatic logic [2:0] expPin(int p, int b);
    logic c, d;
    c = cfgM[p][b];
    d = datM[p][b];
    if (p == SP && b == 6) return 3'b000;
    if (p == SP && b == 7) return crystalMode ? {1'b1, oscOut, 1'b0} : 3'b000;
    if (p == SP && b == 1 && wdogEnable) return {!wdogSig, 1'b0, 1'b1};
    return {c, c & d, !c & d};
  endfunction

  task automatic checkPads(int p, string tag);
    logic [W-1:0] eOe, eOut, ePull;
    for (int b = 0; b < W; b++) begin
      logic [2:0] e;
      e = expPin(p, b);
      eOe[b] = e[2]; eOut[b] = e[1]; ePull[b] = e[0];
    end
    check({tag, " oe"},   32'(padOe[p*W +: W]),     32'(eOe));
    check({tag, " out"},  32'(padOut[p*W +: W]),    32'(eOut));
    check({tag, " pull"}, 32'(padPullUp[p*W +: W]), 32'(ePull));
  endtask

  // write; returns at the negedge after the write edge
  task automatic busWrite(int p, int r, logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; portSel = 2'(p); regSel = 2'(r); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (r == 0) cfgM[p] = d;
    if (r == 1) datM[p] = (p == SP) ? (d & 8'h3F) : d;
  endtask

  task automatic readCheck(int p, int r, logic [W-1:0] exp, string tag);
    portSel = 2'(p); regSel = 2'(r);
    #1;
    check(tag, 32'(rdData), 32'(exp));
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #2000000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst = 1'b1; wrEn = 1'b0; portSel = '0; regSel = '0; wrData = '0;
    padIn = '0; wdogEnable = 1'b0; wdogSig = 1'b0; crystalMode = 1'b0; oscOut = 1'b0;
    for (int p = 0; p < NP; p++) begin cfgM[p] = '0; datM[p] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 padOe", 32'(padOe), 32'h0);
    check("R1 padPullUp", 32'(padPullUp), 32'h0);
    check("R1 pulses/options", {28'h0, haltReq, idleReq, altSkPhase, clkStartDelay}, 32'h0);
    for (int p = 0; p < NP; p++) begin
      readCheck(p, 0, 8'h00, "R1 cfg read");
      readCheck(p, 1, 8'h00, "R1 dat read");
    end

    // R2 directed: all four modes on port 0
    busWrite(0, 0, 8'h0F);
    busWrite(0, 1, 8'h35);
    checkPads(0, "R2 directed modes");
    check("R2 port0 explicit oe", 32'(padOe[7:0]), 32'h0F);
    check("R2 port0 explicit out/pull", {16'h0, padOut[7:0], padPullUp[7:0]}, {16'h0, 8'h05, 8'h30});

    // random writes with model comparison
    for (int i = 0; i < 120; i++) begin
      int p, r;
      logic [W-1:0] d;
      p = $urandom % NP;
      r = $urandom % 2;
      d = W'($urandom);
      busWrite(p, r, d);
      check("R4 halt pulse", 32'(haltReq), 32'(p == SP && r == 1 && d[7]));
      check("R5 idle pulse", 32'(idleReq), 32'(p == SP && r == 1 && d[6]));
      readCheck(p, r, (r == 0) ? cfgM[p] : datM[p], (p == SP) ? "R6 special readback" : "R3 readback");
      checkPads(p, (p == SP) ? "R8 special pads" : "R2 random pads");
    end

    // R4/R5 pulse width: both bits in one write, then both drop
    busWrite(SP, 1, 8'hC5);
    check("R4 halt high", 32'(haltReq), 32'd1);
    check("R5 idle high", 32'(idleReq), 32'd1);
    readCheck(SP, 1, 8'h05, "R6 bits 7:6 read zero");
    @(negedge clk);
    check("R4 halt one cycle", 32'(haltReq), 32'd0);
    check("R5 idle one cycle", 32'(idleReq), 32'd0);
    busWrite(2, 1, 8'hC0);
    check("R4 no halt for other port", 32'(haltReq), 32'd0);

    // R3 pin location and two-edge latency
    begin
      logic [NP*W-1:0] v;
      v = {$urandom, $urandom} & ~(32'(1) << (SP*W+7));
      @(negedge clk);
      padIn = v;
      @(negedge clk);
      readCheck(3, 2, 8'h00, "R3 pins not yet visible");
      @(negedge clk);
      for (int p = 0; p < NP; p++) readCheck(p, 2, v[p*W +: W], "R3 pin levels");
      readCheck(2, 3, 8'h00, "R3 selector 3 reads zero");
    end
    busWrite(2, 2, 8'hAA);
    busWrite(2, 3, 8'h55);
    readCheck(2, 0, cfgM[2], "R3 cfg unchanged by sel 2/3");
    readCheck(2, 1, datM[2], "R3 dat unchanged by sel 2/3");

    // R7 option bits
    busWrite(SP, 0, 8'hC0);
    check("R7 both options", {30'h0, altSkPhase, clkStartDelay}, 32'h3);
    busWrite(SP, 0, 8'h40);
    check("R7 alt phase only", {30'h0, altSkPhase, clkStartDelay}, 32'h2);
    busWrite(SP, 0, 8'h80);
    check("R7 delay only", {30'h0, altSkPhase, clkStartDelay}, 32'h1);

    // R8 pin 6 with register bits that would drive it
    busWrite(SP, 0, 8'h42);
    busWrite(SP, 1, 8'h42);
    check("R8 pin6 oe", 32'(padOe[SP*W+6]), 32'd0);
    check("R8 pin6 pull", 32'(padPullUp[SP*W+6]), 32'd0);
    checkPads(SP, "R8 special pads");

    // R9 watchdog takeover of pin 1 (cfg=1, dat=0 would drive low)
    busWrite(SP, 1, 8'h00);
    wdogEnable = 1'b1; wdogSig = 1'b1;
    #1;
    check("R9 wdog high released", {29'h0, padOe[SP*W+1], padOut[SP*W+1], padPullUp[SP*W+1]}, 32'b001);
    wdogSig = 1'b0;
    #1;
    check("R9 wdog low driven", {29'h0, padOe[SP*W+1], padOut[SP*W+1], padPullUp[SP*W+1]}, 32'b101);
    checkPads(SP, "R9 special pads");
    wdogEnable = 1'b0;
    #1;
    check("R9 register control back", 32'(padOe[SP*W+1]), 32'd1);

    // R10 crystal clock output
    crystalMode = 1'b1; oscOut = 1'b1;
    #1;
    check("R10 xtal drives 1", {30'h0, padOe[SP*W+7], padOut[SP*W+7]}, 32'b11);
    oscOut = 1'b0;
    #1;
    check("R10 xtal drives 0", {30'h0, padOe[SP*W+7], padOut[SP*W+7]}, 32'b10);
    // rising pin 7 while crystal mode: no wake
    @(negedge clk);
    padIn[SP*W+7] = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 no wake in crystal mode", 32'(wakeReq), 32'd0);
    @(negedge clk);
    padIn[SP*W+7] = 1'b0;
    crystalMode = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 pin7 floats", {30'h0, padOe[SP*W+7], padPullUp[SP*W+7]}, 32'b00);
    padIn[SP*W+7] = 1'b1;
    @(negedge clk);
    check("R10 wake not yet", 32'(wakeReq), 32'd0);
    @(negedge clk);
    check("R10 wake pulse", 32'(wakeReq), 32'd1);
    @(negedge clk);
    check("R10 wake one cycle", 32'(wakeReq), 32'd0);

    // R1 reset again clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < NP; p++) begin cfgM[p] = '0; datM[p] = '0; end
    readCheck(SP, 0, 8'h00, "R1 cfg cleared after reset");
    check("R1 pads after reset", 32'(padOe | padPullUp), 32'h0);

    finishRun();
  end
endmodule